// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

The block turns a byte stream from a transmit FIFO into one serial bit per clock enable. In framed mode the line idles with continuous flags. When a frame is waiting, it can send an optional repeated preamble pattern, then a sync byte of ones, then an opening flag. The payload follows with zero-bit insertion, then a 16-bit frame check sequence, then a closing flag. With shared flags enabled, one flag both ends a frame and opens the next. If the FIFO runs dry inside a frame, the frame is aborted with a run of ones and a one-cycle underrun pulse is raised.

In transparent mode there is no framing. The line idles at all ones. After a start pulse, one 0xFF sync byte is sent, then the FIFO bytes are sent raw. With the cyclic option held, the block tells the FIFO to rewind each time the last byte of a pass is taken, so the same contents go out again and again. Clearing the option ends the repetition at the end of the current pass.

Every byte goes out least significant bit first. The FIFO interface is a valid/pop pair with an end-of-frame marker on each byte. The FIFO presents the head byte combinationally, and a pop takes effect at the next clock edge.

Top module: `hdlc_txf`

## Requirements
- R1: In framed mode with no frame waiting, the output is an unbroken stream of 0x7E flags, sent as 0,1,1,1,1,1,1,0.
- R2: A framed transfer is sent in this order: opening flag, payload bytes (each LSB first, the last one being the FIFO byte marked last), two check bytes, closing flag.
- R3: Inside the payload and check fields, a 0 is inserted after every five consecutive 1s, including at a field's end. Flags, preamble, sync and abort bytes are never stuffed.
- R4: The check field is the ones' complement of a CRC-16 (polynomial 0x1021, preset 0xFFFF). The register is fed the payload bits in line order, and the complement is sent from register bit 15 down to bit 0.
- R5: With shared flags on, a frame that is waiting when the previous closing flag ends starts right after that single flag. With shared flags off, exactly two flags separate back-to-back frames.
- R6: With the preamble enabled, after the timefill flag the pattern is sent n+1 times (n being the repeat field) without stuffing. Then come one 0xFF sync byte, an opening flag and the payload.
- R7: If the FIFO is empty when the next payload byte of a framed transfer is due, an unstuffed 0xFF abort byte is sent, then flags resume. The underrun output pulses for exactly one cycle.
- R8: In transparent mode the line idles at 1. Nothing is popped until a start pulse arrives. After it, one 0xFF sync byte and then the FIFO bytes are sent raw, with no flags, check field or stuffing. After the byte marked last, the line returns to idle ones until the next start.
- R9: In transparent mode with the cyclic option set, popping the byte marked last also pulses the rewind output, and transmission carries on from the first byte. Once the option is cleared, the pass in progress completes and popping stops.
- R10: The serial output changes only after a clock edge on which the bit enable was high.
- R11: A byte is popped only while the FIFO reports valid, at most once per eight emitted data bits, and exactly once per payload byte.
- R12: During and right after reset the output is 1, and the first byte sent after reset is a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit is emitted per cycle with this high |
| cfg_transparent | input | 1 | 1 selects raw transparent mode, 0 framed mode |
| cfg_cyclic | input | 1 | Repeat FIFO contents in transparent mode |
| cfg_shared_flag | input | 1 | Let one flag close a frame and open the next |
| cfg_pre_en | input | 1 | Send the preamble before each framed transfer |
| cfg_pre_pattern | input | 8 | Preamble byte |
| cfg_pre_reps | input | PRE_CNT_W | Preamble repeat field; n sends n+1 copies |
| start | input | 1 | Start pulse for transparent transmission |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | Head byte of the FIFO |
| fifo_last | input | 1 | Head byte ends a frame or pass |
| fifo_pop | output | 1 | Take the head byte at this clock edge |
| fifo_rewind | output | 1 | Reset the FIFO read point to the first byte (cyclic) |
| underrun | output | 1 | One-cycle pulse on a framed abort |
| ser_out | output | 1 | Serial line output |

## Verification
Framed transfers are driven with payloads that differ in how they stress the stuffing logic. Runs of 0xFF force stuffing in mid-byte and across byte borders. Embedded 0x7E bytes must come out stuffed and never as flags. Bytes that end on five ones check the insertion right before the check field and the closing flag. Each captured bit stream is compared with an expected stream that the bench builds on its own, including a CRC computed bytewise. Back-to-back frames are run with shared flags on and off, so a single and a doubled flag separator tell the two apart. A sweep of preamble repeat counts and patterns with long runs of ones shows whether the preamble is stuffed or repeated the wrong number of times. Transparent tests use bytes that would be stuffed or taken for flags in framed mode, and a cyclic run checks the repeat and the clean stop.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;
  localparam int          BYTE_W     = 8;
  localparam int          CRC_W      = 16;
  localparam int          STUFF_RUN  = 5;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ONES_BYTE  = 8'hFF;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  // kind of byte currently in the shifter
  typedef enum logic [2:0] {
    ST_FILL, ST_PRE, ST_SYNC, ST_OPEN, ST_DATA, ST_FCS_HI, ST_FCS_LO, ST_ABORT
  } seq_st_e;

  // one CRC step for a single line bit
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? CRC_POLY : 16'h0000);
  endfunction

  // reverse so that register bit 15 leaves first under LSB-first shifting
  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = x[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/hdlc_txf_ser.sv
module hdlc_txf_ser
  import hdlc_txf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic [7:0]  ld_byte,
  input  logic        ld_stuff,
  input  logic        ld_crc,
  input  logic        ld_crc_init,
  output logic        byte_done,
  output logic        stuff_ins,
  output logic [15:0] crc_nx,
  output logic        ser_out
);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam int BCNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [BCNT_W-1:0] bcnt;
  logic [ONES_W-1:0] ones;
  logic [CRC_W-1:0]  crc_q;
  logic              stuff_en, crc_en, stuff_pend;
  logic              shift_bit;

  assign shift_bit = bit_en && !stuff_pend;
  assign stuff_ins = bit_en && stuff_pend;
  assign byte_done = shift_bit && (bcnt == BCNT_W'(BYTE_W - 1));
  assign crc_nx    = (shift_bit && crc_en) ? crc_bit(crc_q, sh[0]) : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh         <= FLAG_BYTE;
      bcnt       <= '0;
      ones       <= '0;
      crc_q      <= CRC_PRESET;
      stuff_en   <= 1'b0;
      crc_en     <= 1'b0;
      stuff_pend <= 1'b0;
      ser_out    <= 1'b1;
    end else if (stuff_ins) begin
      ser_out    <= 1'b0;
      stuff_pend <= 1'b0;
      ones       <= '0;
    end else if (shift_bit) begin
      ser_out <= sh[0];
      bcnt    <= bcnt + 1'b1;
      if (stuff_en && sh[0]) begin
        if (ones == ONES_W'(STUFF_RUN - 1)) begin
          stuff_pend <= 1'b1;
          ones       <= '0;
        end else begin
          ones <= ones + 1'b1;
        end
      end else begin
        ones <= '0;
      end
      if (byte_done) begin
        sh       <= ld_byte;
        stuff_en <= ld_stuff;
        crc_en   <= ld_crc;
        crc_q    <= ld_crc_init ? CRC_PRESET : crc_nx;
      end else begin
        sh    <= {1'b0, sh[BYTE_W-1:1]};
        crc_q <= crc_nx;
      end
    end
  end
endmodule

// File: rtl/hdlc_txf_seq.sv
module hdlc_txf_seq
  import hdlc_txf_pkg::*;
#(
  parameter int PRE_CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_transparent,
  input  logic                 cfg_cyclic,
  input  logic                 cfg_shared_flag,
  input  logic                 cfg_pre_en,
  input  logic [7:0]           cfg_pre_pattern,
  input  logic [PRE_CNT_W-1:0] cfg_pre_reps,
  input  logic                 start,
  input  logic                 fifo_valid,
  input  logic [7:0]           fifo_data,
  input  logic                 fifo_last,
  input  logic                 byte_done,
  input  logic [15:0]          crc_nx,
  output logic                 fifo_pop,
  output logic                 fifo_rewind,
  output logic                 underrun,
  output logic [7:0]           ld_byte,
  output logic                 ld_stuff,
  output logic                 ld_crc,
  output logic                 ld_crc_init
);
  seq_st_e              st, nx_st;
  logic [PRE_CNT_W-1:0] pre_cnt, nx_pre;
  logic                 need_open, nx_need;
  logic                 go, nx_go;
  logic                 cur_last, nx_last;
  logic                 want_data, data_first;

  always_comb begin
    nx_st = st; nx_pre = pre_cnt; nx_need = need_open;
    nx_go = go | start; nx_last = cur_last;
    ld_byte = FLAG_BYTE; ld_stuff = 1'b0; ld_crc = 1'b0; ld_crc_init = 1'b0;
    fifo_pop = 1'b0; fifo_rewind = 1'b0; underrun = 1'b0;
    want_data = 1'b0; data_first = 1'b0;
    if (byte_done) begin
      case (st)
        ST_FILL: begin
          if (cfg_transparent) begin
            ld_byte = ONES_BYTE;
            if (go) nx_st = ST_SYNC;
          end else if (fifo_valid && !need_open) begin
            if (cfg_pre_en) begin
              ld_byte = cfg_pre_pattern; nx_st = ST_PRE; nx_pre = '0;
            end else begin
              want_data = 1'b1; data_first = 1'b1;
            end
          end else begin
            nx_need = 1'b0;
          end
        end
        ST_PRE: begin
          if (pre_cnt == cfg_pre_reps) begin
            ld_byte = ONES_BYTE; nx_st = ST_SYNC;
          end else begin
            ld_byte = cfg_pre_pattern; nx_pre = pre_cnt + 1'b1;
          end
        end
        ST_SYNC: begin
          if (cfg_transparent) want_data = 1'b1;
          else nx_st = ST_OPEN;
        end
        ST_OPEN: begin
          want_data = 1'b1; data_first = 1'b1;
        end
        ST_DATA: begin
          if (!cur_last) begin
            want_data = 1'b1;
          end else if (cfg_transparent) begin
            ld_byte = ONES_BYTE; nx_st = ST_FILL; nx_go = start;
          end else begin
            ld_byte = rev8(~crc_nx[15:8]); nx_st = ST_FCS_HI;
          end
        end
        ST_FCS_HI: begin
          ld_byte = rev8(~crc_nx[7:0]); ld_stuff = 1'b1; nx_st = ST_FCS_LO;
        end
        ST_FCS_LO: begin
          nx_st = ST_FILL; nx_need = !cfg_shared_flag;
        end
        default: begin
          nx_st = ST_FILL; nx_need = 1'b0;
        end
      endcase
      // check bytes are stuffed like payload
      if (st == ST_DATA && cur_last && !cfg_transparent) ld_stuff = 1'b1;
      if (want_data) begin
        if (cfg_transparent) begin
          nx_st = ST_DATA;
          if (fifo_valid) begin
            fifo_pop = 1'b1; ld_byte = fifo_data;
            fifo_rewind = fifo_last && cfg_cyclic;
            nx_last = fifo_last && !cfg_cyclic;
          end else begin
            ld_byte = ONES_BYTE; nx_last = 1'b0;
          end
        end else if (fifo_valid) begin
          fifo_pop = 1'b1; ld_byte = fifo_data; ld_stuff = 1'b1; ld_crc = 1'b1;
          ld_crc_init = data_first; nx_last = fifo_last; nx_st = ST_DATA;
        end else begin
          ld_byte = ONES_BYTE; nx_st = ST_ABORT; underrun = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_FILL; pre_cnt <= '0; need_open <= 1'b0; go <= 1'b0; cur_last <= 1'b0;
    end else begin
      st <= nx_st; pre_cnt <= nx_pre; need_open <= nx_need; go <= nx_go; cur_last <= nx_last;
    end
  end
endmodule

// File: rtl/hdlc_txf.sv
module hdlc_txf
  import hdlc_txf_pkg::*;
#(
  parameter int PRE_CNT_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 cfg_transparent,
  input  logic                 cfg_cyclic,
  input  logic                 cfg_shared_flag,
  input  logic                 cfg_pre_en,
  input  logic [7:0]           cfg_pre_pattern,
  input  logic [PRE_CNT_W-1:0] cfg_pre_reps,
  input  logic                 start,
  input  logic                 fifo_valid,
  input  logic [7:0]           fifo_data,
  input  logic                 fifo_last,
  output logic                 fifo_pop,
  output logic                 fifo_rewind,
  output logic                 underrun,
  output logic                 ser_out
);
  // internal events, visible to the bound checker
  logic        byte_done;
  logic        stuff_ins;
  logic [15:0] crc_nx;
  logic [7:0]  ld_byte;
  logic        ld_stuff, ld_crc, ld_crc_init;

  hdlc_txf_seq #(.PRE_CNT_W(PRE_CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_transparent(cfg_transparent), .cfg_cyclic(cfg_cyclic),
    .cfg_shared_flag(cfg_shared_flag), .cfg_pre_en(cfg_pre_en),
    .cfg_pre_pattern(cfg_pre_pattern), .cfg_pre_reps(cfg_pre_reps),
    .start(start), .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .byte_done(byte_done), .crc_nx(crc_nx),
    .fifo_pop(fifo_pop), .fifo_rewind(fifo_rewind), .underrun(underrun),
    .ld_byte(ld_byte), .ld_stuff(ld_stuff), .ld_crc(ld_crc), .ld_crc_init(ld_crc_init)
  );

  hdlc_txf_ser u_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .ld_byte(ld_byte), .ld_stuff(ld_stuff), .ld_crc(ld_crc), .ld_crc_init(ld_crc_init),
    .byte_done(byte_done), .stuff_ins(stuff_ins), .crc_nx(crc_nx), .ser_out(ser_out)
  );
endmodule

// File: rtl/hdlc_txf_chk.sv
module hdlc_txf_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic cfg_transparent,
  input logic cfg_cyclic,
  input logic fifo_valid,
  input logic fifo_last,
  input logic fifo_pop,
  input logic fifo_rewind,
  input logic underrun,
  input logic byte_done,
  input logic stuff_ins,
  input logic ser_out
);
  // R3
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_ins |=> !ser_out);
  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));
  // R11
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_valid && byte_done));
  // R9
  rewind_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rewind |-> (fifo_pop && fifo_last && cfg_cyclic && cfg_transparent));
  // R7
  underrun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!fifo_valid && !fifo_pop && !cfg_transparent));
  // R7
  underrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);
endmodule

bind hdlc_txf hdlc_txf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
  .cfg_transparent(cfg_transparent), .cfg_cyclic(cfg_cyclic),
  .fifo_valid(fifo_valid), .fifo_last(fifo_last), .fifo_pop(fifo_pop),
  .fifo_rewind(fifo_rewind), .underrun(underrun),
  .byte_done(byte_done), .stuff_ins(stuff_ins), .ser_out(ser_out)
);

// File: tb/hdlc_txf_bench.sv
module hdlc_txf_bench;
  localparam int PRE_CNT_W = 3;
  localparam int CAP_N = 16384;
  localparam int EXP_N = 2048;
  localparam int FB_N  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic en_req = 1'b0, gate_mode = 1'b0;
  logic cfg_transparent = 1'b0, cfg_cyclic = 1'b0, cfg_shared_flag = 1'b0, cfg_pre_en = 1'b0;
  logic [7:0] cfg_pre_pattern = 8'h00;
  logic [PRE_CNT_W-1:0] cfg_pre_reps = '0;
  logic start = 1'b0;
  logic fifo_valid, fifo_last, fifo_pop, fifo_rewind, underrun, ser_out;
  logic [7:0] fifo_data;

  always #10 clk = ~clk;

  hdlc_txf #(.PRE_CNT_W(PRE_CNT_W)) u_hdlc_txf (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cfg_transparent(cfg_transparent), .cfg_cyclic(cfg_cyclic),
    .cfg_shared_flag(cfg_shared_flag), .cfg_pre_en(cfg_pre_en),
    .cfg_pre_pattern(cfg_pre_pattern), .cfg_pre_reps(cfg_pre_reps),
    .start(start), .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_pop(fifo_pop), .fifo_rewind(fifo_rewind), .underrun(underrun), .ser_out(ser_out)
  );

  // FIFO model
  logic [7:0] fbuf [FB_N];
  logic       flast_m [FB_N];
  int flen = 0, frd = 0;
  logic f_rst = 1'b0, fen = 1'b0;
  assign fifo_valid = fen && (frd < flen);
  assign fifo_data  = (frd < FB_N) ? fbuf[frd] : 8'h00;
  assign fifo_last  = (frd < FB_N) ? flast_m[frd] : 1'b0;

  int n_pop = 0, n_rew = 0, n_urun = 0, cyc = 0;
  logic en_q = 1'b0;
  always @(posedge clk) begin
    en_q <= bit_en;
    cyc  <= cyc + 1;
    if (f_rst) frd <= 0;
    else if (fifo_pop) frd <= fifo_rewind ? 0 : frd + 1;
    if (fifo_pop) n_pop <= n_pop + 1;
    if (fifo_rewind) n_rew <= n_rew + 1;
    if (underrun) n_urun <= n_urun + 1;
  end

  always @(negedge clk) bit_en <= gate_mode ? ~bit_en : en_req;

  // line capture
  logic cap [CAP_N];
  int cap_n = 0, hold_err = 0;
  logic last_out = 1'b1;
  always @(negedge clk) begin
    if (en_q && cap_n < CAP_N) begin cap[cap_n] = ser_out; cap_n = cap_n + 1; end
    if (!en_q && ser_out !== last_out) hold_err = hold_err + 1;
    last_out = ser_out;
  end

  int n_tests = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    summary();
  end

  // expected stream builder
  logic ex [EXP_N];
  int ex_n = 0, st_ones = 0;
  logic [7:0] pay [FB_N];

  function automatic logic [7:0] flip(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction
  task automatic ex_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin ex[ex_n] = b[i]; ex_n++; end
  endtask
  task automatic ex_sbit(input logic v);
    ex[ex_n] = v; ex_n++;
    if (v) begin
      st_ones++;
      if (st_ones == 5) begin ex[ex_n] = 1'b0; ex_n++; st_ones = 0; end
    end else st_ones = 0;
  endtask
  task automatic ex_payload(input int first, input int n, input bit with_fcs);
    logic [15:0] c;
    c = 16'hFFFF; st_ones = 0;
    for (int k = first; k < first + n; k++) begin
      for (int i = 0; i < 8; i++) ex_sbit(pay[k][i]);
      c = c ^ {flip(pay[k]), 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
    end
    if (with_fcs) begin
      c = ~c;
      for (int i = 15; i >= 0; i--) ex_sbit(c[i]);
    end
  endtask
  function automatic int find_ex(input int from);
    for (int s = (from < 0 ? 0 : from); s + ex_n <= cap_n; s++) begin
      bit m = 1'b1;
      for (int i = 0; i < ex_n && m; i++) if (cap[s+i] !== ex[i]) m = 1'b0;
      if (m) return s;
    end
    return -1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic fifo_load(input int n, input int la, input int lb);
    fen = 1'b0; f_rst = 1'b1; tick(1); f_rst = 1'b0;
    for (int i = 0; i < FB_N; i++) begin
      fbuf[i] = (i < n) ? pay[i] : 8'h00;
      flast_m[i] = (i == la) || (i == lb);
    end
    flen = n; fen = 1'b1;
  endtask
  task automatic set_case(input int k, output int n);
    case (k)
      0: begin pay[0] = 8'hA5; n = 1; end
      1: begin pay[0] = 8'hFF; pay[1] = 8'hFF; n = 2; end
      2: begin pay[0] = 8'h7E; pay[1] = 8'h7E; pay[2] = 8'h7E; n = 3; end
      3: begin pay[0] = 8'h00; pay[1] = 8'h01; pay[2] = 8'h02; pay[3] = 8'h03; n = 4; end
      4: begin pay[0] = 8'hF8; pay[1] = 8'h01; pay[2] = 8'h3E; pay[3] = 8'h1F; pay[4] = 8'h7C; n = 5; end
      default: begin pay[0] = 8'h55; pay[1] = 8'hAA; pay[2] = 8'h0F; pay[3] = 8'hF0;
                     pay[4] = 8'hC3; pay[5] = 8'h3C; n = 6; end
    endcase
  endtask

  initial begin
    int base, pos, p0, r0, u0, n;
    for (int i = 0; i < FB_N; i++) begin fbuf[i] = 8'h00; flast_m[i] = 1'b0; end
    // R12 reset state
    tick(5);
    check(ser_out === 1'b1, "R12", "line during reset", ser_out, 1);
    rst_n = 1'b1; tick(2);
    check(ser_out === 1'b1, "R12", "line after reset before enable", ser_out, 1);
    en_req = 1'b1; tick(60);
    ex_n = 0; ex_raw(8'h7E);
    check(find_ex(0) == 0, "R12", "first byte is a flag", find_ex(0), 0);
    ex_n = 0; repeat (5) ex_raw(8'h7E);
    check(find_ex(0) == 0, "R1", "idle flags", find_ex(0), 0);

    // R2 R3 R4 R11 framed payload sweep
    for (int k = 0; k < 6; k++) begin
      set_case(k, n);
      base = cap_n - 16; p0 = n_pop;
      fifo_load(n, n - 1, -1); tick(n * 12 + 100);
      ex_n = 0; ex_raw(8'h7E); ex_payload(0, n, 1'b1); ex_raw(8'h7E);
      pos = find_ex(base);
      check(pos >= 0, "R2", $sformatf("framed case %0d stream with R3 stuffing and R4 fcs", k), pos, 0);
      check(n_pop - p0 == n, "R11", $sformatf("pops case %0d", k), n_pop - p0, n);
    end

    // R5 shared flags
    pay[0] = 8'h11; pay[1] = 8'hFF; pay[2] = 8'h22; pay[3] = 8'h7E; pay[4] = 8'hF8;
    cfg_shared_flag = 1'b1; base = cap_n - 16;
    fifo_load(5, 2, 4); tick(250);
    ex_n = 0; ex_raw(8'h7E); ex_payload(0, 3, 1'b1); ex_raw(8'h7E); ex_payload(3, 2, 1'b1); ex_raw(8'h7E);
    pos = find_ex(base);
    check(pos >= 0, "R5", "single shared flag", pos, 0);
    cfg_shared_flag = 1'b0; base = cap_n - 16;
    fifo_load(5, 2, 4); tick(250);
    pos = find_ex(base);
    check(pos < 0, "R5", "no shared flag when disabled", pos, -1);
    ex_n = 0; ex_raw(8'h7E); ex_payload(0, 3, 1'b1); ex_raw(8'h7E); ex_raw(8'h7E);
    ex_payload(3, 2, 1'b1); ex_raw(8'h7E);
    pos = find_ex(base);
    check(pos >= 0, "R5", "two flags between frames", pos, 0);

    // R6 preamble sweep
    cfg_pre_en = 1'b1;
    for (int r = 0; r < 4; r++) begin
      cfg_pre_reps = PRE_CNT_W'(r);
      cfg_pre_pattern = (r % 2 == 0) ? 8'h3F : 8'hFD;
      pay[0] = 8'h5A; pay[1] = 8'hFF;
      base = cap_n - 16;
      fifo_load(2, 1, -1); tick(200);
      ex_n = 0; ex_raw(8'h7E);
      for (int c = 0; c <= r; c++) ex_raw(cfg_pre_pattern);
      ex_raw(8'hFF); ex_raw(8'h7E); ex_payload(0, 2, 1'b1); ex_raw(8'h7E);
      pos = find_ex(base);
      check(pos >= 0, "R6", $sformatf("preamble reps %0d", r), pos, 0);
    end
    cfg_pre_en = 1'b0;

    // R7 underrun
    pay[0] = 8'hC3; pay[1] = 8'hFF;
    base = cap_n - 16; p0 = n_pop; u0 = n_urun;
    fifo_load(2, -1, -1); tick(150);
    ex_n = 0; ex_raw(8'h7E); ex_payload(0, 2, 1'b0); ex_raw(8'hFF); ex_raw(8'h7E);
    pos = find_ex(base);
    check(pos >= 0, "R7", "abort stream", pos, 0);
    check(n_urun - u0 == 1, "R7", "underrun pulses", n_urun - u0, 1);
    check(n_pop - p0 == 2, "R11", "pops before abort", n_pop - p0, 2);

    // R8 transparent
    cfg_transparent = 1'b1; fen = 1'b0; tick(30);
    pay[0] = 8'h7E; pay[1] = 8'hF8; pay[2] = 8'h01; pay[3] = 8'h00;
    p0 = n_pop; fifo_load(4, 3, -1); tick(60);
    check(n_pop == p0, "R8", "no pop before start", n_pop - p0, 0);
    base = cap_n - 16;
    start = 1'b1; tick(1); start = 1'b0; tick(120);
    ex_n = 0; ex_raw(8'hFF); for (int i = 0; i < 4; i++) ex_raw(pay[i]); ex_raw(8'hFF);
    pos = find_ex(base);
    check(pos >= 0, "R8", "raw stream", pos, 0);
    check(n_pop - p0 == 4, "R8", "transparent pops", n_pop - p0, 4);
    p0 = n_pop; fifo_load(2, 1, -1); tick(60);
    check(n_pop == p0, "R8", "idle again after last byte", n_pop - p0, 0);

    // R9 cyclic
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'hA5;
    cfg_cyclic = 1'b1; r0 = n_rew; p0 = n_pop;
    fifo_load(3, 2, -1); base = cap_n - 16;
    start = 1'b1; tick(1); start = 1'b0; tick(160);
    ex_n = 0; ex_raw(8'hFF); repeat (3) for (int i = 0; i < 3; i++) ex_raw(pay[i]);
    pos = find_ex(base);
    check(pos >= 0, "R9", "repeated passes", pos, 0);
    check(n_rew - r0 >= 2, "R9", "rewinds", n_rew - r0, 2);
    cfg_cyclic = 1'b0; tick(60);
    n = n_pop; tick(60);
    check(n_pop == n, "R9", "popping stopped", n_pop - n, 0);
    check((n_pop - p0) % 3 == 0, "R9", "whole passes", (n_pop - p0) % 3, 0);
    pos = 0; for (int i = cap_n - 16; i < cap_n; i++) if (cap[i] !== 1'b1) pos++;
    check(pos == 0, "R9", "line back to ones", pos, 0);

    // R10 gated bit enable
    cfg_transparent = 1'b0; fen = 1'b0; tick(40);
    gate_mode = 1'b1; set_case(4, n); base = cap_n - 16;
    fifo_load(n, n - 1, -1); tick(n * 24 + 200);
    ex_n = 0; ex_raw(8'h7E); ex_payload(0, n, 1'b1); ex_raw(8'h7E);
    pos = find_ex(base);
    check(pos >= 0, "R10", "frame under gated enable", pos, 0);
    check(hold_err == 0, "R10", "line changed without enable", hold_err, 0);
    summary();
  end
endmodule